// File: doc/BRIEF.md
# UART FIFO Control and Threshold Logic

This block sits between a UART's serializers and its host interface. It owns a transmit queue and a receive queue, one byte wide and sixteen deep by default, and a one-byte control word that is loaded through a simple write strobe. The push and pop strobes for both queues come from outside; the block itself only stores data, tracks fill levels and turns those levels into interrupt, flow-control and DMA request signals.

The control word switches the queues between full-depth operation and a single-entry holding mode, flushes either queue on command, picks one of two DMA request styles, and selects the fill levels at which the receive interrupt, the transmit-threshold interrupt, the automatic RTS line and the DMA requests change state. A parameter decides whether the transmit threshold can be programmed at all; when it cannot, the transmit interrupt fires only on an empty queue.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the control word is all zeros: both queues hold 0 entries, the receive interrupt is low, the transmit-threshold interrupt is high, rts_n is low, rx_dma_req_n is high and tx_dma_req_n is low.
- R2: A control write whose bit 0 (queue enable) differs from the stored value empties both queues in that cycle; a write that keeps bit 0 and has bits 1 and 2 clear leaves both queues untouched.
- R3: A control write with bit 1 set empties the receive queue only; the bit is not stored, so later writes with bit 1 clear do not empty it again.
- R4: A control write with bit 2 set empties the transmit queue only and is likewise not stored.
- R5: With bit 0 set each queue holds DEPTH entries returned in push order; a push to a full queue and a pop from an empty queue are ignored.
- R6: With bit 0 clear each queue holds one entry, the receive trigger level is 1 and the transmit threshold is 0 whatever bits 7:6 and 5:4 hold.
- R7: rx_avail_irq is high while the receive level is at or above the trigger chosen by bits 7:6: 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives DEPTH-2.
- R8: tx_thr_irq is high while the transmit level is at or below the threshold chosen by bits 5:4: 0 gives 0, 1 gives 2, 2 gives DEPTH/4, 3 gives DEPTH/2.
- R9: With PROG_THRE=0 writes to bits 5:4 are ignored and the transmit threshold stays 0.
- R10: With flow_auto_en high, rts_n is high exactly while rx_avail_irq is high; with flow_auto_en low, rts_n is low.
- R11: With bit 3 (DMA style) clear, rx_dma_req_n is low while the receive queue is not empty and tx_dma_req_n is low while the transmit queue is not full.
- R12: With bit 3 set, rx_dma_req_n goes low when the receive level reaches its trigger and stays low until the queue is empty; tx_dma_req_n goes low when the transmit level is at or below its threshold and stays low until the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| flow_auto_en | input | 1 | Enables automatic RTS control |
| tx_push | input | 1 | Host writes a byte to the transmit queue |
| tx_wdata | input | 8 | Byte pushed to the transmit queue |
| tx_pop | input | 1 | Serializer takes a byte from the transmit queue |
| tx_rdata | output | 8 | Oldest byte in the transmit queue |
| rx_push | input | 1 | Serializer delivers a byte to the receive queue |
| rx_wdata | input | 8 | Byte pushed to the receive queue |
| rx_pop | input | 1 | Host reads a byte from the receive queue |
| rx_rdata | output | 8 | Oldest byte in the receive queue |
| tx_level | output | 5 | Transmit queue fill level |
| rx_level | output | 5 | Receive queue fill level |
| rx_avail_irq | output | 1 | Receive trigger interrupt |
| tx_thr_irq | output | 1 | Transmit threshold interrupt |
| rts_n | output | 1 | Active-low request-to-send |
| rx_dma_req_n | output | 1 | Active-low receive DMA request |
| tx_dma_req_n | output | 1 | Active-low transmit DMA request |

## Verification
The hardest state to reach is the hysteresis of the second DMA style: a request that was raised at a trigger level must stay up as the queue drains or fills past that level, which only shows after a full climb and a full descent under every trigger setting. The bench therefore sweeps all sixteen combinations of receive and transmit trigger codes, alternating the DMA style and the flow-control enable, and for each one fills both queues one byte past capacity and drains them one byte past empty, comparing every output after every step against an arithmetic model. A second instance built without a programmable transmit threshold shares the same stimulus to show its threshold field cannot be written.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef struct packed {
    logic [1:0] rx_trig;
    logic [1:0] tx_trig;
    logic       dma_style;
    logic       q_enable;
  } fifo_cfg_t;

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
  import uart_fifo_pkg::*;
#(
  parameter bit PROG_THRE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output fifo_cfg_t  cfg_q,
  output logic       rx_flush,
  output logic       tx_flush
);

  fifo_cfg_t cfg_d;
  logic      en_toggle;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.q_enable  = cfg_wdata[0];
      cfg_d.dma_style = cfg_wdata[3];
      cfg_d.rx_trig   = cfg_wdata[7:6];
      if (PROG_THRE) begin
        cfg_d.tx_trig = cfg_wdata[5:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  assign en_toggle = cfg_we && (cfg_wdata[0] != cfg_q.q_enable);
  assign rx_flush  = (cfg_we && cfg_wdata[1]) || en_toggle;
  assign tx_flush  = (cfg_we && cfg_wdata[2]) || en_toggle;

  AST_RX_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[1]) |=> (!rx_flush || cfg_we)); // R3
  AST_TX_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[2]) |=> (!tx_flush || cfg_we)); // R4

endmodule

// File: rtl/uart_fifo_queue.sv
module uart_fifo_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              q_enable,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     level
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CW-1:0]     cap;
  logic              push_ok, pop_ok;

  assign cap     = q_enable ? FULL_LVL : CW'(1);
  assign push_ok = push && !flush && (cnt_q < cap);
  assign pop_ok  = pop && !flush && (cnt_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) begin
        wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + AW'(1);
      end
      if (pop_ok) begin
        rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + AW'(1);
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr_q] <= wdata;
    end
  end

  assign rdata = mem[rd_ptr_q];
  assign level = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= cap); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0)); // R2
  AST_FULL_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && (level == cap)) |=> $stable(level)); // R5

endmodule

// File: rtl/uart_fifo_thresh.sv
module uart_fifo_thresh
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fifo_cfg_t     cfg,
  input  logic          flow_auto_en,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_level,
  output logic          rx_avail_irq,
  output logic          tx_thr_irq,
  output logic          rts_n,
  output logic          rx_dma_req_n,
  output logic          tx_dma_req_n
);

  localparam logic [CW-1:0] LVL_QUART = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL_HALF  = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL_NFULL = CW'(DEPTH - 2);
  localparam logic [CW-1:0] LVL_FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_ONE   = CW'(1);
  localparam logic [CW-1:0] LVL_TWO   = CW'(2);

  logic [CW-1:0] rx_trig_lvl, tx_thr_lvl, tx_cap;
  logic          rx_hit, tx_hit;
  logic          rx_hold_q, rx_hold_d, tx_hold_q, tx_hold_d;
  logic          rx_req, tx_req;

  always_comb begin
    rx_trig_lvl = LVL_ONE;
    tx_thr_lvl  = '0;
    if (cfg.q_enable) begin
      case (cfg.rx_trig)
        2'd0:    rx_trig_lvl = LVL_ONE;
        2'd1:    rx_trig_lvl = LVL_QUART;
        2'd2:    rx_trig_lvl = LVL_HALF;
        default: rx_trig_lvl = LVL_NFULL;
      endcase
      case (cfg.tx_trig)
        2'd0:    tx_thr_lvl = '0;
        2'd1:    tx_thr_lvl = LVL_TWO;
        2'd2:    tx_thr_lvl = LVL_QUART;
        default: tx_thr_lvl = LVL_HALF;
      endcase
    end
  end

  assign tx_cap = cfg.q_enable ? LVL_FULL : LVL_ONE;
  assign rx_hit = rx_level >= rx_trig_lvl;
  assign tx_hit = tx_level <= tx_thr_lvl;

  assign rx_avail_irq = rx_hit;
  assign tx_thr_irq   = tx_hit;
  assign rts_n        = flow_auto_en && rx_hit;

  always_comb begin
    if (cfg.dma_style) begin
      rx_req = rx_hit || (rx_hold_q && (rx_level != '0));
      tx_req = tx_hit || (tx_hold_q && (tx_level != tx_cap));
    end else begin
      rx_req = rx_level != '0;
      tx_req = tx_level != tx_cap;
    end
    rx_hold_d = cfg.dma_style && rx_req;
    tx_hold_d = cfg.dma_style && tx_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold_q <= 1'b0;
      tx_hold_q <= 1'b0;
    end else begin
      rx_hold_q <= rx_hold_d;
      tx_hold_q <= tx_hold_d;
    end
  end

  assign rx_dma_req_n = !rx_req;
  assign tx_dma_req_n = !tx_req;

  AST_RX_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dma_style && !rx_dma_req_n) |=> (!cfg.dma_style || (rx_level == '0) || !rx_dma_req_n)); // R12
  AST_TX_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dma_style && !tx_dma_req_n) |=> (!cfg.dma_style || (tx_level == tx_cap) || !tx_dma_req_n)); // R12
  AST_THRE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |-> tx_thr_irq); // R8
  AST_RTS_MANUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_auto_en |-> !rts_n); // R10

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 16,
  parameter bit PROG_THRE = 1'b1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              flow_auto_en,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  output logic [CW-1:0]     tx_level,
  output logic [CW-1:0]     rx_level,
  output logic              rx_avail_irq,
  output logic              tx_thr_irq,
  output logic              rts_n,
  output logic              rx_dma_req_n,
  output logic              tx_dma_req_n
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  fifo_cfg_t  cfg;
  logic       rx_flush, tx_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  uart_fifo_cfg #(.PROG_THRE(PROG_THRE)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg),
    .rx_flush  (rx_flush),
    .tx_flush  (tx_flush)
  );

  uart_fifo_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) txq_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .flush    (tx_flush),
    .q_enable (cfg.q_enable),
    .push     (tx_push),
    .wdata    (tx_wdata),
    .pop      (tx_pop),
    .rdata    (tx_rdata),
    .level    (tx_level)
  );

  uart_fifo_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rxq_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .flush    (rx_flush),
    .q_enable (cfg.q_enable),
    .push     (rx_push),
    .wdata    (rx_wdata),
    .pop      (rx_pop),
    .rdata    (rx_rdata),
    .level    (rx_level)
  );

  uart_fifo_thresh #(.DEPTH(DEPTH)) thr_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cfg          (cfg),
    .flow_auto_en (flow_auto_en),
    .rx_level     (rx_level),
    .tx_level     (tx_level),
    .rx_avail_irq (rx_avail_irq),
    .tx_thr_irq   (tx_thr_irq),
    .rts_n        (rts_n),
    .rx_dma_req_n (rx_dma_req_n),
    .tx_dma_req_n (tx_dma_req_n)
  );

  AST_DISABLED_DEPTH_ONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg.q_enable |-> ((rx_level <= CW'(1)) && (tx_level <= CW'(1)))); // R6

endmodule

// File: tb/uart_fifo_ctrl_tb_top.sv
module uart_fifo_ctrl_tb_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       flow_auto_en = 1'b0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0;
  logic [7:0] tx_rdata, rx_rdata, l_tx_rdata, l_rx_rdata;
  logic [4:0] tx_level, rx_level, l_tx_level, l_rx_level;
  logic       rx_avail_irq, tx_thr_irq, rts_n, rx_dma_req_n, tx_dma_req_n;
  logic       l_rx_avail_irq, l_tx_thr_irq, l_rts_n, l_rx_dma_req_n, l_tx_dma_req_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit m_en, m_dma, m_auto;
  int m_rxt, m_txt;
  bit m_rx_hold, m_tx_hold;
  logic [7:0] mrx[$];
  logic [7:0] mtx[$];

  always #5 clk = ~clk;

  uart_fifo_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .flow_auto_en(flow_auto_en),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .tx_level(tx_level), .rx_level(rx_level), .rx_avail_irq(rx_avail_irq),
    .tx_thr_irq(tx_thr_irq), .rts_n(rts_n), .rx_dma_req_n(rx_dma_req_n),
    .tx_dma_req_n(tx_dma_req_n)
  );

  uart_fifo_ctrl #(.DEPTH(DEPTH), .PROG_THRE(1'b0)) dut_lock_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .flow_auto_en(flow_auto_en),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(l_tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(l_rx_rdata),
    .tx_level(l_tx_level), .rx_level(l_rx_level), .rx_avail_irq(l_rx_avail_irq),
    .tx_thr_irq(l_tx_thr_irq), .rts_n(l_rts_n), .rx_dma_req_n(l_rx_dma_req_n),
    .tx_dma_req_n(l_tx_dma_req_n)
  );

  function automatic int cap_of();
    return m_en ? DEPTH : 1;
  endfunction

  function automatic int rx_trig_of();
    if (!m_en) return 1;
    case (m_rxt)
      0: return 1;
      1: return DEPTH / 4;
      2: return DEPTH / 2;
      default: return DEPTH - 2;
    endcase
  endfunction

  function automatic int tx_thr_of(input bit prog);
    if (!m_en || !prog) return 0;
    case (m_txt)
      0: return 0;
      1: return 2;
      2: return DEPTH / 4;
      default: return DEPTH / 2;
    endcase
  endfunction

  function automatic bit rx_req_of();
    int l = mrx.size();
    if (!m_dma) return l != 0;
    return (l >= rx_trig_of()) || (m_rx_hold && l != 0);
  endfunction

  function automatic bit tx_req_of();
    int l = mtx.size();
    if (!m_dma) return l != cap_of();
    return (l <= tx_thr_of(1'b1)) || (m_tx_hold && l != cap_of());
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit rxh = mrx.size() >= rx_trig_of();
    chk("R5 rx_level", int'(rx_level), mrx.size());
    chk("R5 tx_level", int'(tx_level), mtx.size());
    if (mrx.size() > 0) chk("R5 rx_rdata", int'(rx_rdata), int'(mrx[0]));
    if (mtx.size() > 0) chk("R5 tx_rdata", int'(tx_rdata), int'(mtx[0]));
    chk("R7 rx_avail_irq", int'(rx_avail_irq), int'(rxh));
    chk("R8 tx_thr_irq", int'(tx_thr_irq), int'(mtx.size() <= tx_thr_of(1'b1)));
    chk("R10 rts_n", int'(rts_n), int'(m_auto && rxh));
    chk(m_dma ? "R12 rx_dma_req_n" : "R11 rx_dma_req_n", int'(rx_dma_req_n), int'(!rx_req_of()));
    chk(m_dma ? "R12 tx_dma_req_n" : "R11 tx_dma_req_n", int'(tx_dma_req_n), int'(!tx_req_of()));
    chk("R9 locked tx_thr_irq", int'(l_tx_thr_irq), int'(mtx.size() <= tx_thr_of(1'b0)));
  endtask

  // one clock of stimulus: model holds advance with pre-edge state, then the change applies
  task automatic op(input bit we, input logic [7:0] wd, input bit tp, input bit tpo,
                    input bit rp, input bit rpo, input logic [7:0] d);
    bit nrx = rx_req_of();
    bit ntx = tx_req_of();
    m_rx_hold = m_dma && nrx;
    m_tx_hold = m_dma && ntx;
    if (we) begin
      if (wd[0] != m_en || wd[1]) mrx.delete();
      if (wd[0] != m_en || wd[2]) mtx.delete();
      m_en  = wd[0];
      m_dma = wd[3];
      m_txt = int'(wd[5:4]);
      m_rxt = int'(wd[7:6]);
    end else begin
      if (tp && mtx.size() < cap_of()) mtx.push_back(d);
      if (tpo && mtx.size() > 0) void'(mtx.pop_front());
      if (rp && mrx.size() < cap_of()) mrx.push_back(d ^ 8'h5A);
      if (rpo && mrx.size() > 0) void'(mrx.pop_front());
    end
    cfg_we = we; cfg_wdata = wd;
    tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo;
    tx_wdata = d; rx_wdata = d ^ 8'h5A;
    @(negedge clk);
    cfg_we = 1'b0; tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    check_all();
  endtask

  task automatic wcfg(input logic [7:0] wd);
    op(1'b1, wd, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_dma = 0; m_auto = 0; m_rxt = 0; m_txt = 0;
    m_rx_hold = 0; m_tx_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 rx_level", int'(rx_level), 0);
    chk("R1 tx_level", int'(tx_level), 0);
    chk("R1 rx_avail_irq", int'(rx_avail_irq), 0);
    chk("R1 tx_thr_irq", int'(tx_thr_irq), 1);
    chk("R1 rts_n", int'(rts_n), 0);
    chk("R1 rx_dma_req_n", int'(rx_dma_req_n), 1);
    chk("R1 tx_dma_req_n", int'(tx_dma_req_n), 0);

    // R6 single-entry holding mode, including a queue-enable-clear write with trigger codes
    for (int m = 0; m < 2; m++) begin
      wcfg(8'hF0 | (m[0] ? 8'h08 : 8'h00));
      op(0, 0, 1, 0, 1, 0, 8'h11);
      op(0, 0, 1, 0, 1, 0, 8'h22);   // ignored: depth one
      chk("R6 rx depth one", int'(rx_level), 1);
      op(0, 0, 0, 1, 0, 1, 8'h00);
      op(0, 0, 0, 1, 0, 1, 8'h00);   // pop empty ignored
    end

    // R2 enable toggle flushes both; same-enable write keeps contents
    wcfg(8'h01);
    for (int i = 0; i < 5; i++) op(0, 0, 1, 0, 1, 0, 8'(8'h30 + i));
    wcfg(8'h41);
    chk("R2 rx kept", int'(rx_level), 5);
    chk("R2 tx kept", int'(tx_level), 5);
    wcfg(8'h00);
    chk("R2 rx flushed on disable", int'(rx_level), 0);
    op(0, 0, 1, 0, 1, 0, 8'h44);
    wcfg(8'h01);
    chk("R2 tx flushed on enable", int'(tx_level), 0);

    // R3 receive-only flush, self-clearing
    for (int i = 0; i < 6; i++) op(0, 0, 1, 0, 1, 0, 8'(8'h50 + i));
    wcfg(8'h03);
    chk("R3 rx flushed", int'(rx_level), 0);
    chk("R3 tx kept", int'(tx_level), 6);
    op(0, 0, 0, 0, 1, 0, 8'h66);
    wcfg(8'h01);
    chk("R3 bit not stored", int'(rx_level), 1);

    // R4 transmit-only flush, self-clearing
    wcfg(8'h05);
    chk("R4 tx flushed", int'(tx_level), 0);
    chk("R4 rx kept", int'(rx_level), 1);
    op(0, 0, 1, 0, 0, 0, 8'h77);
    wcfg(8'h01);
    chk("R4 bit not stored", int'(tx_level), 1);
    wcfg(8'h07);

    // sweep: R5 R7 R8 R9 R10 R11 R12 over every trigger pair
    for (int rt = 0; rt < 4; rt++) begin
      for (int tt = 0; tt < 4; tt++) begin
        m_auto = tt[0] ^ rt[0];
        flow_auto_en = m_auto;
        wcfg(8'(8'h01 | (rt << 6) | (tt << 4) | ((rt + tt) % 2 == 1 ? 8'h08 : 8'h00)));
        for (int i = 0; i <= DEPTH; i++) op(0, 0, 1, 0, 1, 0, 8'(i * 7 + rt * 16 + tt));
        for (int i = 0; i <= DEPTH; i++) op(0, 0, 0, 1, 0, 1, 8'h00);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule